// File: doc/BRIEF.md
# Wired-Interrupt to Vector-Message Converter

This block collects up to 64 wired interrupt lines and turns each active, permitted line into a message that carries an 8-bit vector. Software sets each line up through a 32-bit register bus. Each line can be edge- or level-sensitive, with either polarity, and has its own mask bit, message-enable bit, vector byte and route byte. Lines in edge mode capture their events in latches. Software clears a latch by writing a 1 to the matching bit of a write-only clear word.

Each cycle the converter looks at the lines that are pending, unmasked and enabled, and picks the lowest-numbered one. It then raises `msg_valid` with that line's vector and holds the message until the receiver asserts `msg_ready`. A level line that has been sent must drop before it can send again. An edge line sends once for each latch, and the latch stays set until software clears it. A capability field reports how many lines the block supports.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset both mask words read 0xFFFFFFFF. The enable, sense-mode, polarity, bounce, route and vector storage all read 0, and `msg_valid` is low.
- R2: A read of offset 0x004 returns 0x003F0000, so bits 23:16 hold the line count minus one. Offset 0x000, the write-only clear words at 0x080/0x084, and any undecoded offset all read 0.
- R3: Route bytes sit at 0x100+n and vector bytes at 0x200+n. Byte lane b of the word at offset 4k belongs to line 4k+b. A write changes only the lanes whose byte enable is set.
- R4: The bounce words at 0xC0/0xC4 and 0xE0/0xE4 and the route bytes read back what was written, and they have no effect on message generation.
- R5: When the sense bit is 0 (level mode), polarity bit 0 makes the line active-high and polarity bit 1 makes it active-low.
- R6: When the sense bit is 1 (edge mode), polarity bit 0 latches a rising edge and polarity bit 1 latches a falling edge. The opposite transition latches nothing.
- R7: Writing 1 to a clear bit (0x080 covers lines 0..31, 0x084 covers lines 32..63) discards that line's latched edge. Writing 0 leaves it untouched.
- R8: A mask bit of 1 (0x020/0x024) stops the line from producing a message. Unmasking a line that is already pending lets its message out.
- R9: A line produces a message only while its enable bit (0x040/0x044) is 1. The message carries that line's vector byte.
- R10: When several lines qualify, the lowest-numbered one is sent first.
- R11: `msg_valid` and `msg_vector` stay unchanged until `msg_ready` is seen. After the handshake `msg_valid` drops for at least one cycle.
- R12: A level line that has been sent does not send again until it deasserts and asserts once more. An edge line sends once per latch, even while the latch stays set.
- R13: If a clear write and a newly detected edge hit the same line in the same cycle, the new edge wins and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Asynchronous interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector of the offered message |

## Verification
Two functions can act in the same cycle: software clearing a latch, and the synchronizer reporting a fresh edge on that same line. The bench drives a rising input while the line is masked. It counts the synchronizer stages so that the clear-word write commits on exactly the edge at which the latch would set. Unmasking afterwards must release a message, which shows the new edge survived the clear. A control run commits the same clear one cycle later, and no message may appear.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 10;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        BK_NONE,
        BK_CAP,
        BK_MASK,
        BK_MSGEN,
        BK_SENSE,
        BK_CLR,
        BK_BNC0,
        BK_BNC1,
        BK_POL,
        BK_ROUTE,
        BK_VEC
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic       hi;      // second word of a two-word bank
        logic [5:0] tword;   // word index within a byte table
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.bank  = BK_NONE;
        d.hi    = a[2];
        d.tword = a[7:2];
        case (a[9:8])
            2'b01:   d.bank = BK_ROUTE;
            2'b10:   d.bank = BK_VEC;
            default: begin
                case (a[9:3])
                    7'h00:   d.bank = BK_CAP;
                    7'h04:   d.bank = BK_MASK;
                    7'h08:   d.bank = BK_MSGEN;
                    7'h0C:   d.bank = BK_SENSE;
                    7'h10:   d.bank = BK_CLR;
                    7'h18:   d.bank = BK_BNC0;
                    7'h1C:   d.bank = BK_BNC1;
                    7'h7C:   d.bank = BK_POL;
                    default: d.bank = BK_NONE;
                endcase
            end
        endcase
        return d;
    endfunction

    function automatic logic [REG_W-1:0] lane_mask(input logic [3:0] be);
        logic [REG_W-1:0] m;
        for (int b = 0; b < 4; b++) m[b*BYTE_W +: BYTE_W] = {BYTE_W{be[b]}};
        return m;
    endfunction

    function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old_v,
                                               input logic [REG_W-1:0] new_v,
                                               input logic [REG_W-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/irqmsg_regs.sv
module irqmsg_regs
    import irqmsg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [REG_W-1:0]                 wdata,
    input  logic [3:0]                       be,
    output logic [REG_W-1:0]                 rdata,
    output logic [NUM_SRC-1:0]               mask_o,
    output logic [NUM_SRC-1:0]               en_o,
    output logic [NUM_SRC-1:0]               sense_o,
    output logic [NUM_SRC-1:0]               pol_o,
    output logic [NUM_SRC-1:0]               clr_o,
    output logic [NUM_SRC-1:0][BYTE_W-1:0]   vec_o
);
    localparam int unsigned NWORDS = NUM_SRC / REG_W;
    localparam int unsigned TWORDS = NUM_SRC / 4;

    dec_t             dec;
    logic [REG_W-1:0] wm;
    assign dec = decode(addr);
    assign wm  = lane_mask(be);

    logic [NWORDS-1:0][REG_W-1:0] mask_q, en_q, sense_q, pol_q, bnc0_q, bnc1_q;
    logic [NUM_SRC-1:0][BYTE_W-1:0] route_q, vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            en_q    <= '0;
            sense_q <= '0;
            pol_q   <= '0;
            bnc0_q  <= '0;
            bnc1_q  <= '0;
            route_q <= '0;
            vec_q   <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (int'(dec.hi) == w) begin
                    case (dec.bank)
                        BK_MASK:  mask_q[w]  <= merge(mask_q[w],  wdata, wm);
                        BK_MSGEN: en_q[w]    <= merge(en_q[w],    wdata, wm);
                        BK_SENSE: sense_q[w] <= merge(sense_q[w], wdata, wm);
                        BK_POL:   pol_q[w]   <= merge(pol_q[w],   wdata, wm);
                        BK_BNC0:  bnc0_q[w]  <= merge(bnc0_q[w],  wdata, wm);
                        BK_BNC1:  bnc1_q[w]  <= merge(bnc1_q[w],  wdata, wm);
                        default: ;
                    endcase
                end
            end
            for (int n = 0; n < NUM_SRC; n++) begin
                if (int'(dec.tword) == n / 4 && be[n % 4]) begin
                    if (dec.bank == BK_ROUTE) route_q[n] <= wdata[(n % 4)*BYTE_W +: BYTE_W];
                    if (dec.bank == BK_VEC)   vec_q[n]   <= wdata[(n % 4)*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // one-cycle write-one-to-clear strobes toward the latches
    always_comb begin
        clr_o = '0;
        if (wr_en && dec.bank == BK_CLR) begin
            for (int w = 0; w < NWORDS; w++)
                if (int'(dec.hi) == w) clr_o[w*REG_W +: REG_W] = wdata & wm;
        end
    end

    // read path
    logic [NWORDS-1:0][REG_W-1:0] bank_rd;
    always_comb begin
        case (dec.bank)
            BK_MASK:  bank_rd = mask_q;
            BK_MSGEN: bank_rd = en_q;
            BK_SENSE: bank_rd = sense_q;
            BK_POL:   bank_rd = pol_q;
            BK_BNC0:  bank_rd = bnc0_q;
            BK_BNC1:  bank_rd = bnc1_q;
            default:  bank_rd = '0;
        endcase
        rdata = '0;
        if (int'(dec.hi) < NWORDS) rdata = bank_rd[dec.hi];
        if (dec.bank == BK_CAP && dec.hi)
            rdata[23:16] = BYTE_W'(NUM_SRC - 1);
        if (dec.bank == BK_ROUTE || dec.bank == BK_VEC) begin
            for (int t = 0; t < TWORDS; t++) begin
                if (int'(dec.tword) == t) begin
                    for (int b = 0; b < 4; b++)
                        rdata[b*BYTE_W +: BYTE_W] = (dec.bank == BK_ROUTE) ?
                            route_q[t*4 + b] : vec_q[t*4 + b];
                end
            end
        end
    end

    assign mask_o  = mask_q;
    assign en_o    = en_q;
    assign sense_o = sense_q;
    assign pol_o   = pol_q;
    assign vec_o   = vec_q;

    AST_MASK_SET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_o == '1)); // R1

    AST_MASK_QUIET_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_o)); // R8

endmodule

// File: rtl/irqmsg_sense.sv
module irqmsg_sense #(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] sense_i,   // 1 = edge, 0 = level
    input  logic [NUM_SRC-1:0] pol_i,     // 1 = falling / active-low
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] accept_i,
    output logic [NUM_SRC-1:0] ready_o
);
    logic [NUM_SRC-1:0] sync1, sync2, sync3, latch_q, sent_q;
    logic [NUM_SRC-1:0] act, act_d, edge_set, pend;

    assign act      = sync2 ^ pol_i;
    assign act_d    = sync3 ^ pol_i;
    assign edge_set = sense_i & act & ~act_d;
    assign pend     = (sense_i & latch_q) | (~sense_i & act);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1   <= '0;
            sync2   <= '0;
            sync3   <= '0;
            latch_q <= '0;
            sent_q  <= '0;
        end else begin
            sync1   <= irq_in;
            sync2   <= sync1;
            sync3   <= sync2;
            latch_q <= edge_set | (latch_q & ~clr_i);   // new edge beats clear
            sent_q  <= pend & (sent_q | accept_i);       // re-arms once pending drops
        end
    end

    assign ready_o = pend & ~sent_q;

endmodule

// File: rtl/irqmsg_arb.sv
module irqmsg_arb
    import irqmsg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             elig_i,
    input  logic [NUM_SRC-1:0][BYTE_W-1:0] vec_tab,
    input  logic                           msg_ready,
    output logic                           msg_valid,
    output logic [BYTE_W-1:0]              msg_vector,
    output logic [NUM_SRC-1:0]             accept_o
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic             found;
    logic [IDX_W-1:0] sel, idx_q;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid  <= 1'b0;
            msg_vector <= '0;
            idx_q      <= '0;
        end else if (!msg_valid && found) begin
            msg_valid  <= 1'b1;
            msg_vector <= vec_tab[sel];
            idx_q      <= sel;
        end else if (msg_valid && msg_ready) begin
            msg_valid  <= 1'b0;
        end
    end

    assign accept_o = (msg_valid && msg_ready) ?
                      ({{(NUM_SRC-1){1'b0}}, 1'b1} << idx_q) : '0;

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid); // R11

    AST_VECTOR_STABLE: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> $stable(msg_vector)); // R11

    AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid); // R11

    AST_LAUNCH_WHEN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        !msg_valid && (|elig_i) |=> msg_valid); // R10

    AST_NO_SPURIOUS_MESSAGE: assert property (@(posedge clk) disable iff (rst)
        !msg_valid && !(|elig_i) |=> !msg_valid); // R9

endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
    import irqmsg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  irq_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic [3:0]          bus_be,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [BYTE_W-1:0]   msg_vector
);
    logic [NUM_SRC-1:0]             mask_bits, en_bits, sense_bits, pol_bits, clr_bits;
    logic [NUM_SRC-1:0]             ready_bits, accept_bits, elig_bits;
    logic [NUM_SRC-1:0][BYTE_W-1:0] vec_tab;

    irqmsg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .rdata   (bus_rdata),
        .mask_o  (mask_bits),
        .en_o    (en_bits),
        .sense_o (sense_bits),
        .pol_o   (pol_bits),
        .clr_o   (clr_bits),
        .vec_o   (vec_tab)
    );

    irqmsg_sense #(.NUM_SRC(NUM_SRC)) u_sense (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .sense_i  (sense_bits),
        .pol_i    (pol_bits),
        .clr_i    (clr_bits),
        .accept_i (accept_bits),
        .ready_o  (ready_bits)
    );

    assign elig_bits = ready_bits & ~mask_bits & en_bits;

    irqmsg_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .elig_i     (elig_bits),
        .vec_tab    (vec_tab),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector),
        .accept_o   (accept_bits)
    );

endmodule

// File: tb/irq_msg_ctrl_bench.sv
`timescale 1ns/1ps
module irq_msg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_msg_ctrl u_irq_msg_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; irq_in = '0; msg_ready = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wrb(input logic [9:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = b;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        wrb(a, d, 4'hF);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_vec(input int n, input logic [7:0] v);
        wrb(10'h200 + 10'(n & ~3), 32'(v) << (8 * (n % 4)), 4'b0001 << (n % 4));
    endtask

    task automatic expect_msg(input logic [7:0] v, input string tag);
        for (int i = 0; i < 12 && !msg_valid; i++) @(negedge clk);
        chk({31'd0, msg_valid}, 32'd1, {tag, " valid"});
        chk({24'd0, msg_vector}, {24'd0, v}, {tag, " vector"});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_none(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen++;
        end
        chk(32'(seen), 32'd0, {tag, " no message"});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(10'h020, d); chk(d, 32'hFFFF_FFFF, "R1 mask0");
        rd(10'h024, d); chk(d, 32'hFFFF_FFFF, "R1 mask1");
        rd(10'h044, d); chk(d, 32'h0, "R1 enable1");
        rd(10'h060, d); chk(d, 32'h0, "R1 sense0");
        rd(10'h3E4, d); chk(d, 32'h0, "R1 pol1");
        rd(10'h2FC, d); chk(d, 32'h0, "R1 vector table");
        chk({31'd0, msg_valid}, 32'd0, "R1 msg_valid");
    endtask

    task automatic t_readout();
        logic [31:0] d;
        rd(10'h004, d); chk(d, 32'h003F_0000, "R2 capability");
        rd(10'h000, d); chk(d, 32'h0, "R2 offset0");
        wr(10'h080, 32'hFFFF_FFFF);
        rd(10'h080, d); chk(d, 32'h0, "R2 clear write-only");
        rd(10'h010, d); chk(d, 32'h0, "R2 undefined");
        rd(10'h3C0, d); chk(d, 32'h0, "R2 undefined high");
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        do_reset();
        set_vec(5, 8'hAB);
        rd(10'h204, d); chk(d, 32'h0000_AB00, "R3 vector lane1");
        wr(10'h108, 32'h1122_3344);
        wrb(10'h108, 32'h0055_0000, 4'b0100);
        rd(10'h108, d); chk(d, 32'h1155_3344, "R3 route byte lane");
        wr(10'h0C4, 32'hDEAD_BEEF);
        wr(10'hE0, 32'hFFFF_FFFF);
        rd(10'h0C4, d); chk(d, 32'hDEAD_BEEF, "R4 bounce readback");
        wr(10'h100, 32'hFFFF_FFFF);
        set_vec(3, 8'h33);
        wr(10'h040, 32'h0000_0008);
        wr(10'h020, 32'hFFFF_FFF7);
        irq_in[3] = 1'b1;
        expect_msg(8'h33, "R4 route/bounce no effect");
    endtask

    task automatic t_level();
        do_reset();
        set_vec(3, 8'h33);
        wr(10'h040, 32'h0000_0008);
        wr(10'h020, 32'hFFFF_FFF7);
        @(negedge clk) irq_in[3] = 1'b1;
        expect_msg(8'h33, "R5 level high");
        expect_none(10, "R12 level held");
        @(negedge clk) irq_in[3] = 1'b0;
        repeat (5) @(negedge clk);
        irq_in[3] = 1'b1;
        expect_msg(8'h33, "R12 level re-arm");
        do_reset();
        set_vec(3, 8'h3C);
        wr(10'h3E0, 32'h0000_0008);
        @(negedge clk) irq_in[3] = 1'b1;
        wr(10'h040, 32'h0000_0008);
        wr(10'h020, 32'hFFFF_FFF7);
        expect_none(8, "R5 active-low idle");
        @(negedge clk) irq_in[3] = 1'b0;
        expect_msg(8'h3C, "R5 active-low");
    endtask

    task automatic pulse40();
        @(negedge clk) irq_in[40] = 1'b1;
        repeat (4) @(negedge clk);
        irq_in[40] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_edge();
        do_reset();
        set_vec(40, 8'h4E);
        wr(10'h064, 32'h0000_0100);
        wr(10'h044, 32'h0000_0100);
        pulse40();
        expect_none(4, "R8 masked edge");
        wr(10'h024, 32'hFFFF_FEFF);
        expect_msg(8'h4E, "R6 rising latched");
        expect_none(10, "R12 edge once per latch");
        wr(10'h024, 32'hFFFF_FFFF);
        wr(10'h084, 32'hFFFF_FEFF);
        wr(10'h024, 32'hFFFF_FEFF);
        expect_none(8, "R7 clear zero keeps sent latch");
        wr(10'h024, 32'hFFFF_FFFF);
        wr(10'h084, 32'h0000_0100);
        pulse40();
        wr(10'h084, 32'hFFFF_FEFF);
        wr(10'h024, 32'hFFFF_FEFF);
        expect_msg(8'h4E, "R7 write zero no effect");
        wr(10'h024, 32'hFFFF_FFFF);
        wr(10'h084, 32'h0000_0100);
        pulse40();
        wr(10'h084, 32'h0000_0100);
        wr(10'h024, 32'hFFFF_FEFF);
        expect_none(8, "R7 write one clears");
        do_reset();
        set_vec(40, 8'h4F);
        wr(10'h064, 32'h0000_0100);
        wr(10'h3E4, 32'h0000_0100);
        wr(10'h044, 32'h0000_0100);
        wr(10'h024, 32'hFFFF_FEFF);
        @(negedge clk) irq_in[40] = 1'b1;
        expect_none(8, "R6 falling ignores rise");
        @(negedge clk) irq_in[40] = 1'b0;
        expect_msg(8'h4F, "R6 falling latched");
    endtask

    task automatic t_mask_en();
        do_reset();
        set_vec(10, 8'h0A);
        @(negedge clk) irq_in[10] = 1'b1;
        wr(10'h040, 32'h0000_0400);
        expect_none(8, "R8 masked level");
        wr(10'h040, 32'h0);
        wr(10'h020, 32'hFFFF_FBFF);
        expect_none(8, "R9 disabled");
        wr(10'h040, 32'h0000_0400);
        expect_msg(8'h0A, "R9 enabled");
    endtask

    task automatic t_prio();
        int held = 0;
        do_reset();
        set_vec(2, 8'h02);
        set_vec(7, 8'h07);
        set_vec(33, 8'h21);
        wr(10'h040, 32'h0000_0084);
        wr(10'h044, 32'h0000_0002);
        wr(10'h020, 32'hFFFF_FF7B);
        wr(10'h024, 32'hFFFF_FFFD);
        @(negedge clk) begin irq_in[2] = 1'b1; irq_in[7] = 1'b1; irq_in[33] = 1'b1; end
        for (int i = 0; i < 12 && !msg_valid; i++) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            if (msg_valid && msg_vector == 8'h02) held++;
            @(negedge clk);
        end
        chk(32'(held), 32'd6, "R11 held until ready");
        expect_msg(8'h02, "R10 lowest first");
        expect_msg(8'h07, "R10 second");
        expect_msg(8'h21, "R10 upper word");
        expect_none(8, "R12 all sent");
    endtask

    task automatic race(input int extra, input logic [7:0] v);
        do_reset();
        set_vec(0, v);
        wr(10'h060, 32'h1);
        wr(10'h040, 32'h1);
        @(negedge clk) irq_in[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        repeat (extra) @(posedge clk);
        wr(10'h080, 32'h1);
        wr(10'h020, 32'hFFFF_FFFE);
    endtask

    task automatic t_race();
        race(0, 8'h5A);
        expect_msg(8'h5A, "R13 edge beats clear");
        race(1, 8'h5B);
        expect_none(8, "R13 later clear wins");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_readout();
        t_bytes();
        t_level();
        t_edge();
        t_mask_en();
        t_prio();
        t_race();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule